// File: doc/BRIEF.md
# Error Threshold Counter Bank

This block holds a small set of machine-check threshold registers, one per error source. Each register is 64 bits wide. Only its upper word carries state: a 12-bit corrected-error counter, an overflow flag, a two-bit interrupt kind, a count-enable bit and a four-bit interrupt vector offset. Three fixed status bits report whether the slot exists, whether it has a counter, and whether firmware has locked it. Software reaches every slot through one indexed register port, with the slots four address units apart. Each slot also has a one-cycle error event input.

Software arms a slot by writing the counter to 0xFFF minus the wanted limit. It also sets count enable and, if it wants an interrupt, the interrupt kind. Each error event then advances the counter. When the count reaches 0xFFF the slot raises its overflow flag. The shared interrupt output is asserted while any slot has overflow set together with interrupt kind 2'b01. A separate report gives the lowest-numbered slot with overflow set, so a handler knows which slot to service first. A write that clears the counter and the overflow flag re-arms the slot.

Top module: `errthr_bank_top`

## Requirements
- R1: After reset every counter, overflow flag, interrupt kind, count enable and vector offset is zero. Each slot reads back only its status bits: bit 63 exists, bit 62 has-counter, bit 61 locked. With the default parameters all five slots exist, slots 0 to 3 have a counter, and only slot 3 is locked.
- R2: Slot i sits at address 4*i. An address that is not a multiple of four, or that lies beyond the last slot, reads as zero, and a write to it changes no slot.
- R3: A write stores wdata bits 55:52 (vector offset), bit 51 (count enable), bits 50:49 (interrupt kind), bit 48 (overflow) and bits 43:32 (counter). Every other bit reads as zero, except the status bits 63:61, which writes cannot change.
- R4: A write to a slot that lacks the exists bit or the has-counter bit, or that has the locked bit set, is ignored. Error events leave such a slot unchanged.
- R5: An error event adds one to the counter only when count enable is 1. With count enable 0 the counter holds.
- R6: After the counter is loaded with 0xFFF minus L (1 <= L <= 0xFFF) and count enable is set, L-1 events leave overflow clear. The L-th event brings the counter to 0xFFF and sets overflow at the same clock edge.
- R7: Further events with the counter at 0xFFF leave it at 0xFFF with overflow still set.
- R8: A single write of counter 0 with overflow 0 clears both fields together and removes the slot's interrupt request.
- R9: When a write and an error event reach the same slot on the same cycle, the written value is stored and the event is dropped.
- R10: The interrupt output is 1 exactly while some slot has overflow 1 and interrupt kind 2'b01. Kinds 2'b00, 2'b10 and 2'b11 raise no interrupt.
- R11: The source report is valid while any slot has overflow set, whatever its kind. It names the lowest-numbered such slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Register address, slot i at 4*i; also selects the read data |
| reg_wr | input | 1 | Write strobe for the addressed slot |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| err_ev | input | NUM_SLOTS (5) | One error event per slot per cycle |
| thr_irq | output | 1 | Threshold interrupt request |
| src_valid | output | 1 | Some slot has overflow set |
| src_idx | output | IDX_W (3) | Lowest slot index with overflow set |

## Verification
The hardest state to reach from the ports is the step onto 0xFFF after a long run of events, and especially the full limit of 0xFFF, which needs 4095 events from a counter of zero. The bench sweeps every usable slot across the limits 1 to 6 and 0xFFF. It holds the event line high for exactly L-1 cycles, checks that overflow is still clear, applies the last event, and then applies extra events to check that the counter stays at 0xFFF. Another case is a write and an event on the same cycle, which the bench produces by raising both strobes at one falling edge.

// File: rtl/errthr_pkg.sv
package errthr_pkg;

  localparam int          CNT_W    = 12;
  localparam logic [11:0] CNT_TOP  = 12'hFFF;
  localparam logic [1:0]  KIND_IRQ = 2'b01;

  typedef struct packed {
    logic [3:0]       vec_off;
    logic             cnt_en;
    logic [1:0]       kind;
    logic             ovf;
    logic [CNT_W-1:0] cnt;
  } slot_fields_t;

  // place the stored fields and status bits at their fixed positions
  function automatic logic [63:0] pack_word(slot_fields_t f, logic ex, logic hc, logic lk);
    logic [63:0] w;
    w        = '0;
    w[63]    = ex;
    w[62]    = hc;
    w[61]    = lk;
    w[55:52] = f.vec_off;
    w[51]    = f.cnt_en;
    w[50:49] = f.kind;
    w[48]    = f.ovf;
    w[43:32] = f.cnt;
    return w;
  endfunction

  function automatic slot_fields_t unpack_word(logic [63:0] w);
    slot_fields_t f;
    f.vec_off = w[55:52];
    f.cnt_en  = w[51];
    f.kind    = w[50:49];
    f.ovf     = w[48];
    f.cnt     = w[43:32];
    return f;
  endfunction

  // counter step with saturation at the top value
  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] c);
    return (c == CNT_TOP) ? CNT_TOP : c + 1'b1;
  endfunction

endpackage

// File: rtl/errthr_slot.sv
module errthr_slot
  import errthr_pkg::*;
#(
  parameter bit EXISTS  = 1'b1,
  parameter bit HAS_CNT = 1'b1,
  parameter bit LOCKED  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [63:0] wdata,
  input  logic        err_ev,
  output logic [63:0] word,
  output logic        ovf,
  output logic        irq_req
);

  localparam bit USABLE = EXISTS && HAS_CNT && !LOCKED;

  slot_fields_t f;
  logic         usable;
  logic         write_taken;
  logic         count_step;
  logic [11:0]  cnt_next;

  assign usable      = USABLE;
  assign write_taken = wr_hit && usable;
  assign count_step  = err_ev && f.cnt_en && !write_taken;
  assign cnt_next    = bump(f.cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f <= '0;
    end else if (write_taken) begin
      f <= unpack_word(wdata);
    end else if (count_step) begin
      f.cnt <= cnt_next;
      if (cnt_next == CNT_TOP) f.ovf <= 1'b1;
    end
  end

  assign word    = pack_word(f, EXISTS, HAS_CNT, LOCKED);
  assign ovf     = f.ovf;
  assign irq_req = f.ovf && (f.kind == KIND_IRQ);

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !usable |=> $stable(f));

  p_hold_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!f.cnt_en && !write_taken) |=> $stable(f.cnt));

  p_reach_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_step && f.cnt == CNT_TOP - 12'd1) |=> (f.ovf && f.cnt == CNT_TOP));

  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_step && f.cnt == CNT_TOP) |=> (f.ovf && f.cnt == CNT_TOP));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (write_taken && err_ev) |=> (f.cnt == $past(wdata[43:32])));

endmodule

// File: rtl/errthr_pick.sv
module errthr_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ovf_vec,
  output logic             src_valid,
  output logic [IDX_W-1:0] src_idx
);

  // scan from the top down so the lowest set slot is written last
  always_comb begin
    src_valid = 1'b0;
    src_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ovf_vec[i]) begin
        src_valid = 1'b1;
        src_idx   = IDX_W'(i);
      end
    end
  end

  p_lowest_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> (ovf_vec[src_idx] && ((ovf_vec & ~({N{1'b1}} << src_idx)) == '0)));

endmodule

// File: rtl/errthr_bank_top.sv
module errthr_bank_top
  import errthr_pkg::*;
#(
  parameter int                   NUM_SLOTS    = 5,
  parameter int                   ADDR_W       = 8,
  parameter int                   STRIDE       = 4,
  parameter logic [NUM_SLOTS-1:0] SLOT_EXISTS  = 5'b11111,
  parameter logic [NUM_SLOTS-1:0] SLOT_HAS_CNT = 5'b01111,
  parameter logic [NUM_SLOTS-1:0] SLOT_LOCKED  = 5'b01000,
  localparam int                  IDX_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [63:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  input  logic [NUM_SLOTS-1:0] err_ev,
  output logic                 thr_irq,
  output logic                 src_valid,
  output logic [IDX_W-1:0]     src_idx
);

  localparam int SH    = $clog2(STRIDE);
  localparam int SEL_W = ADDR_W - SH;

  logic [SEL_W-1:0]     slot_sel;
  logic                 addr_ok;
  logic [63:0]          words [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] ovf_vec;
  logic [NUM_SLOTS-1:0] irq_vec;

  assign slot_sel = reg_addr[ADDR_W-1:SH];
  assign addr_ok  = (reg_addr[SH-1:0] == '0) && (slot_sel < SEL_W'(NUM_SLOTS));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    errthr_slot #(
      .EXISTS (SLOT_EXISTS[i]),
      .HAS_CNT(SLOT_HAS_CNT[i]),
      .LOCKED (SLOT_LOCKED[i])
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (reg_wr && addr_ok && (slot_sel == SEL_W'(i))),
      .wdata  (reg_wdata),
      .err_ev (err_ev[i]),
      .word   (words[i]),
      .ovf    (ovf_vec[i]),
      .irq_req(irq_vec[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (addr_ok && slot_sel == SEL_W'(i)) reg_rdata = words[i];
    end
  end

  assign thr_irq = |irq_vec;

  errthr_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_vec  (ovf_vec),
    .src_valid(src_valid),
    .src_idx  (src_idx)
  );

  p_irq_has_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |-> src_valid);

  p_bad_addr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> (reg_rdata == '0));

endmodule

// File: tb/errthr_bank_top_tb.sv
module errthr_bank_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic [4:0]  err_ev;
  logic        thr_irq;
  logic        src_valid;
  logic [2:0]  src_idx;

  int vectors = 0;
  int miscompares = 0;

  localparam logic [4:0]  EX   = 5'b11111;
  localparam logic [4:0]  HC   = 5'b01111;
  localparam logic [4:0]  LK   = 5'b01000;
  localparam logic [63:0] JUNK = 64'hFF00_F000_DEAD_BEEF;

  always #10 clk = ~clk;

  errthr_bank_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_ev(err_ev),
    .thr_irq(thr_irq), .src_valid(src_valid), .src_idx(src_idx)
  );

  function automatic logic [63:0] fld(logic [3:0] off, logic cen, logic [1:0] kind,
                                      logic ov, logic [11:0] cnt);
    return {8'h00, off, cen, kind, ov, 4'h0, cnt, 32'h0};
  endfunction

  function automatic logic [63:0] stat(int s);
    return {EX[s], HC[s], LK[s], 61'h0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [63:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic events(logic [4:0] m, int n);
    if (n > 0) begin
      @(negedge clk);
      err_ev = m;
      repeat (n) @(negedge clk);
      err_ev = '0;
    end
  endtask

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int limits[7] = '{1, 2, 3, 4, 5, 6, 4095};
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; err_ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 5; s++) rd_chk("R1 reset", 8'(4*s), stat(s));
    chk("R1 irq", {63'h0, thr_irq}, 64'h0);
    chk("R1 src", {63'h0, src_valid}, 64'h0);

    // R3 field placement, junk bits dropped; R10 kind 11 gives no irq
    wr(8'd4, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R3 ones", 8'd4, stat(1) | fld(4'hF, 1, 2'b11, 1, 12'hFFF));
    #1;
    chk("R10 kind11", {63'h0, thr_irq}, 64'h0);
    chk("R11 src", {60'h0, src_valid, src_idx}, {60'h0, 1'b1, 3'd1});
    wr(8'd4, JUNK);
    rd_chk("R3 junk", 8'd4, stat(1));

    // R2 bad addresses
    wr(8'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'd20, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R2 slot0", 8'd0, stat(0));
    rd_chk("R2 slot1", 8'd4, stat(1));
    rd_chk("R2 misaligned", 8'd5, 64'h0);
    rd_chk("R2 beyond", 8'd20, 64'h0);

    // R4 unusable slots
    wr(8'd12, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'd16, 64'hFFFF_FFFF_FFFF_FFFF);
    events(5'b11000, 5);
    rd_chk("R4 locked", 8'd12, stat(3));
    rd_chk("R4 nocounter", 8'd16, stat(4));

    // R5 count enable gate
    wr(8'd0, fld(4'h3, 0, 2'b00, 0, 12'd5) | JUNK);
    events(5'b00001, 3);
    rd_chk("R5 disabled", 8'd0, stat(0) | fld(4'h3, 0, 2'b00, 0, 12'd5));
    wr(8'd0, fld(4'h3, 1, 2'b00, 0, 12'd5));
    events(5'b00001, 3);
    rd_chk("R5 enabled", 8'd0, stat(0) | fld(4'h3, 1, 2'b00, 0, 12'd8));
    wr(8'd0, 64'h0);

    // R6 R7 R8 sweep over usable slots and limits
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 7; k++) begin
        logic [11:0] pre;
        logic [7:0]  a;
        pre = 12'hFFF - 12'(limits[k]);
        a   = 8'(4*s);
        wr(a, fld(4'(s), 1, 2'b01, 0, pre));
        events(5'(1 << s), limits[k] - 1);
        rd_chk("R6 before", a, stat(s) | fld(4'(s), 1, 2'b01, 0, pre + 12'(limits[k] - 1)));
        chk("R6 no irq", {63'h0, thr_irq}, 64'h0);
        events(5'(1 << s), 1);
        rd_chk("R6 reach", a, stat(s) | fld(4'(s), 1, 2'b01, 1, 12'hFFF));
        chk("R10 irq", {63'h0, thr_irq}, 64'h1);
        chk("R11 idx", {60'h0, src_valid, src_idx}, {60'h0, 1'b1, 3'(s)});
        events(5'(1 << s), 2);
        rd_chk("R7 saturate", a, stat(s) | fld(4'(s), 1, 2'b01, 1, 12'hFFF));
        wr(a, fld(4'(s), 1, 2'b01, 0, 12'd0));
        rd_chk("R8 clear", a, stat(s) | fld(4'(s), 1, 2'b01, 0, 12'd0));
        chk("R8 irq off", {63'h0, thr_irq}, 64'h0);
        wr(a, 64'h0);
      end
    end

    // R9 write beats event on the same cycle
    wr(8'd8, fld(4'h0, 1, 2'b00, 0, 12'd10));
    @(negedge clk);
    reg_addr = 8'd8; reg_wr = 1'b1; reg_wdata = fld(4'h0, 1, 2'b00, 0, 12'd100);
    err_ev = 5'b00100;
    @(negedge clk);
    reg_wr = 1'b0; err_ev = '0;
    rd_chk("R9 write wins", 8'd8, stat(2) | fld(4'h0, 1, 2'b00, 0, 12'd100));
    wr(8'd8, 64'h0);

    // R10 R11 several flagged slots
    wr(8'd8, fld(4'h0, 0, 2'b01, 1, 12'd0));
    wr(8'd4, fld(4'h0, 0, 2'b00, 1, 12'd0));
    #1;
    chk("R10 mixed", {63'h0, thr_irq}, 64'h1);
    chk("R11 lowest", {60'h0, src_valid, src_idx}, {60'h0, 1'b1, 3'd1});
    wr(8'd4, 64'h0);
    #1;
    chk("R11 next", {60'h0, src_valid, src_idx}, {60'h0, 1'b1, 3'd2});
    wr(8'd8, 64'h0);
    #1;
    chk("R10 cleared", {63'h0, thr_irq}, 64'h0);
    chk("R11 none", {63'h0, src_valid}, 64'h0);
    wr(8'd0, fld(4'h0, 0, 2'b10, 1, 12'd0));
    #1;
    chk("R10 kind10", {63'h0, thr_irq}, 64'h0);
    chk("R11 kind10 src", {60'h0, src_valid, src_idx}, {60'h0, 1'b1, 3'd0});

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule